// File: doc/BRIEF.md
# Byte-Wide General-Purpose I/O Port

This block drives eight bidirectional pins for a microcontroller-style core. Software reaches it through a small synchronous bus with a 16-bit address, an 8-bit data path and separate read and write strobes. It holds three registers. A write-only direction register marks each pin as an output or an input. An output-value register supplies the level driven on output pins. A pull-up register selects the weak pull-up on input pins. A fourth address reads back the pin state. The pin levels pass through a two-flop synchronizer before anything inside the block uses them.

The block has two classes of reset. A power-on reset, or entry into hardware standby, clears every register. A manual reset, or software standby, clears only the synchronizer and keeps the register contents. An operating-mode input can take the port away from software and hand it to an external data bus. When this happens, the pin enables and pin levels come from the bus controller, and the direction and pull-up settings stop acting on the pins.

Top module: `gpio_port`

## Requirements
- R1: While `por_n` is low, all pin enables, pin levels and pull-up enables are 0. The direction, output-value and pull-up registers read back as 0 after reset.
- R2: A clock edge at which `hstby` is high clears the direction, output-value and pull-up registers to 0. A bus write in the same cycle is lost.
- R3: A clock edge at which `mrst` or `sstby` is high clears the pin synchronizer, so `xbus_di` reads 0 afterwards. The three registers keep their values through it.
- R4: In software mode (`mode` not 4, 5 or 6), `pin_oe` equals the direction register (1 = output) and `pin_out` equals the output-value register.
- R5: In bus mode (`mode` = 4, 5 or 6), every bit of `pin_oe` equals `xbus_oe` and `pin_out` equals `xbus_do`. The direction register has no effect on the pins, although writes to it are still stored.
- R6: The direction register is written at address 16'hFEBC. A read of that address returns 8'h00.
- R7: The output-value register at 16'hFF6C and the pull-up register at 16'hFF73 are both readable and writable, and a read returns the last value written.
- R8: A read of 16'hFF5C returns, per bit, the output-value bit when that pin is a software-mode output. Otherwise it returns the synchronized pin level. Writes to 16'hFF5C change nothing.
- R9: A change on `pin_in` appears on `xbus_di`, and in pin-state reads, two clock edges after it is sampled.
- R10: `pin_pu` bit i is 1 only in software mode with direction bit i at 0 and pull-up bit i at 1. In bus mode `pin_pu` is 0.
- R11: `rdata` is registered. It carries the addressed value in the cycle after a read strobe, 8'h00 for an unmapped address, and 8'h00 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| hstby | input | 1 | Hardware standby: clears the registers |
| mrst | input | 1 | Manual reset: clears the synchronizer only |
| sstby | input | 1 | Software standby: clears the synchronizer only |
| mode | input | 3 | Operating mode; 4 to 6 select bus mode |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Bus write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven level |
| pin_pu | output | 8 | Per-pin pull-up enable |
| xbus_oe | input | 1 | Bus-mode output enable for the whole byte |
| xbus_do | input | 8 | Bus-mode output data |
| xbus_di | output | 8 | Synchronized pin levels for the bus controller |

## Verification
A write lands one edge after its strobe, so `pin_oe`, `pin_out` and `pin_pu` show the new value in the next cycle. These three outputs follow `mode` and `xbus_*` within the same cycle. A read result is due one edge after the strobe. A pin change is due on `xbus_di` two edges after it is sampled. The bench drives inputs on the falling edge and compares every output 1 ns later against a behavioural model that it advances on each rising edge. As a result, each comparison falls exactly on the cycle in which a result is due. Directed checks on the same grid look at `xbus_di` after one edge and again after two edges, to pin down the synchronizer delay.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int MODE_W = 3;

  localparam logic [15:0] ADR_DIR_DEF = 16'hFEBC;
  localparam logic [15:0] ADR_DAT_DEF = 16'hFF6C;
  localparam logic [15:0] ADR_PIN_DEF = 16'hFF5C;
  localparam logic [15:0] ADR_PUL_DEF = 16'hFF73;

  // Modes 4..6 hand the pins to the external data bus.
  function automatic logic mode_is_xbus(input logic [MODE_W-1:0] m);
    return (m >= MODE_W'(4)) && (m <= MODE_W'(6));
  endfunction
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = clr ? '0 : d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = clr ? '0 : stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int          DW      = 8,
  parameter int          AW      = 16,
  parameter logic [AW-1:0] ADR_DIR = 16'hFEBC,
  parameter logic [AW-1:0] ADR_DAT = 16'hFF6C,
  parameter logic [AW-1:0] ADR_PUL = 16'hFF73
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hstby,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] dat_q,
  output logic [DW-1:0] pul_q
);
  logic          wr_dir, wr_dat, wr_pul, reg_en;
  logic [DW-1:0] dir_d, dat_d, pul_d;

  assign wr_dir = wr && (addr == ADR_DIR);
  assign wr_dat = wr && (addr == ADR_DAT);
  assign wr_pul = wr && (addr == ADR_PUL);
  assign reg_en = hstby || wr_dir || wr_dat || wr_pul;

  always_comb begin
    dir_d = dir_q;
    dat_d = dat_q;
    pul_d = pul_q;
    if (hstby) begin
      dir_d = '0;
      dat_d = '0;
      pul_d = '0;
    end else begin
      if (wr_dir) dir_d = wdata;
      if (wr_dat) dat_d = wdata;
      if (wr_pul) pul_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      pul_q <= '0;
    end else if (reg_en) begin
      dir_q <= dir_d;
      dat_q <= dat_d;
      pul_q <= pul_d;
    end
  end
endmodule

// File: rtl/gpio_port_pinctl.sv
module gpio_port_pinctl
  import gpio_port_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          AW      = 16,
  parameter logic [AW-1:0] ADR_DAT = 16'hFF6C,
  parameter logic [AW-1:0] ADR_PIN = 16'hFF5C,
  parameter logic [AW-1:0] ADR_PUL = 16'hFF73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     dir_q,
  input  logic [DW-1:0]     dat_q,
  input  logic [DW-1:0]     pul_q,
  input  logic [DW-1:0]     pin_sync,
  input  logic              xbus_oe,
  input  logic [DW-1:0]     xbus_do,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  output logic [DW-1:0]     pin_oe,
  output logic [DW-1:0]     pin_out,
  output logic [DW-1:0]     pin_pu,
  output logic [DW-1:0]     rdata
);
  logic          xbus;
  logic [DW-1:0] sw_out;
  logic [DW-1:0] pin_view;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_d;

  assign xbus   = mode_is_xbus(mode);
  assign sw_out = xbus ? '0 : dir_q;

  assign pin_oe  = xbus ? {DW{xbus_oe}} : dir_q;
  assign pin_out = xbus ? xbus_do : dat_q;
  assign pin_pu  = xbus ? '0 : (~dir_q & pul_q);

  assign pin_view = (sw_out & dat_q) | (~sw_out & pin_sync);

  always_comb begin
    if (addr == ADR_DAT)      rd_mux = dat_q;
    else if (addr == ADR_PUL) rd_mux = pul_q;
    else if (addr == ADR_PIN) rd_mux = pin_view;
    else                      rd_mux = '0;  // direction address and unmapped
    rdata_d = rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int          DW          = 8,
  parameter int          AW          = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [AW-1:0] ADR_DIR   = ADR_DIR_DEF,
  parameter logic [AW-1:0] ADR_DAT   = ADR_DAT_DEF,
  parameter logic [AW-1:0] ADR_PIN   = ADR_PIN_DEF,
  parameter logic [AW-1:0] ADR_PUL   = ADR_PUL_DEF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hstby,
  input  logic              mrst,
  input  logic              sstby,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     pin_in,
  output logic [DW-1:0]     pin_oe,
  output logic [DW-1:0]     pin_out,
  output logic [DW-1:0]     pin_pu,
  input  logic              xbus_oe,
  input  logic [DW-1:0]     xbus_do,
  output logic [DW-1:0]     xbus_di
);
  logic          rst_sync_n;
  logic          sync_clr;
  logic [DW-1:0] pin_sync;
  logic [DW-1:0] dir_q, dat_q, pul_q;

  // Power-on reset: asserted asynchronously, released on the clock.
  gpio_port_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(por_n), .clr(1'b0), .d(1'b1), .q(rst_sync_n)
  );

  assign sync_clr = hstby || mrst || sstby;

  gpio_port_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n), .clr(sync_clr), .d(pin_in), .q(pin_sync)
  );

  gpio_port_regs #(
    .DW(DW), .AW(AW), .ADR_DIR(ADR_DIR), .ADR_DAT(ADR_DAT), .ADR_PUL(ADR_PUL)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .hstby(hstby), .wr(wr), .addr(addr),
    .wdata(wdata), .dir_q(dir_q), .dat_q(dat_q), .pul_q(pul_q)
  );

  gpio_port_pinctl #(
    .DW(DW), .AW(AW), .ADR_DAT(ADR_DAT), .ADR_PIN(ADR_PIN), .ADR_PUL(ADR_PUL)
  ) u_pinctl (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode), .dir_q(dir_q), .dat_q(dat_q),
    .pul_q(pul_q), .pin_sync(pin_sync), .xbus_oe(xbus_oe), .xbus_do(xbus_do),
    .rd(rd), .addr(addr), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
    .rdata(rdata)
  );

  assign xbus_di = pin_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          AW      = 16,
  parameter logic [AW-1:0] ADR_DIR = 16'hFEBC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hstby,
  input logic              mrst,
  input logic              sstby,
  input logic [MODE_W-1:0] mode,
  input logic [AW-1:0]     addr,
  input logic              wr,
  input logic              rd,
  input logic [DW-1:0]     rdata,
  input logic [DW-1:0]     pin_in,
  input logic [DW-1:0]     pin_pu,
  input logic [DW-1:0]     xbus_di,
  input logic [DW-1:0]     dir_q,
  input logic [DW-1:0]     dat_q,
  input logic [DW-1:0]     pul_q
);
  logic       clr;
  logic [1:0] age_q;

  assign clr = hstby || mrst || sstby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  a_r2_stby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hstby) |-> (dir_q == '0 && dat_q == '0 && pul_q == '0));

  a_r3_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((mrst || sstby) && !hstby && !wr) |=> ($stable(dir_q) && $stable(dat_q) && $stable(pul_q)));

  a_r3_sync_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst || sstby) |=> (xbus_di == '0));

  a_r9_two_edge_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !$past(clr) && !$past(clr, 2)) |-> (xbus_di == $past(pin_in, 2)));

  a_r10_no_pullup_in_bus_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_xbus(mode) |-> (pin_pu == '0));

  a_r6_dir_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADR_DIR) |=> (rdata == '0));

  a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(.DW(DW), .AW(AW), .ADR_DIR(ADR_DIR)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .hstby(hstby), .mrst(mrst), .sstby(sstby),
  .mode(mode), .addr(addr), .wr(wr), .rd(rd), .rdata(rdata), .pin_in(pin_in),
  .pin_pu(pin_pu), .xbus_di(xbus_di), .dir_q(dir_q), .dat_q(dat_q), .pul_q(pul_q)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  localparam logic [15:0] A_DIR = 16'hFEBC;
  localparam logic [15:0] A_DAT = 16'hFF6C;
  localparam logic [15:0] A_PIN = 16'hFF5C;
  localparam logic [15:0] A_PUL = 16'hFF73;

  logic        clk = 1'b0;
  logic        por_n, hstby, mrst, sstby, wr, rd, xbus_oe;
  logic [2:0]  mode;
  logic [15:0] addr;
  logic [7:0]  wdata, pin_in, xbus_do;
  logic [7:0]  rdata, pin_oe, pin_out, pin_pu, xbus_di;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .por_n(por_n), .hstby(hstby), .mrst(mrst), .sstby(sstby),
    .mode(mode), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
    .xbus_oe(xbus_oe), .xbus_do(xbus_do), .xbus_di(xbus_di)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_dir, m_dat, m_pul, m_rdata;
  logic [7:0] m_sync[$];
  int         m_rcnt;

  function automatic bit bus_mode(input logic [2:0] m);
    return (m == 3'd4) || (m == 3'd5) || (m == 3'd6);
  endfunction

  function automatic logic [7:0] m_read(input logic [15:0] a);
    logic [7:0] view;
    for (int b = 0; b < 8; b++)
      view[b] = (!bus_mode(mode) && m_dir[b]) ? m_dat[b] : m_sync[0][b];
    if (a == A_DAT) return m_dat;
    if (a == A_PUL) return m_pul;
    if (a == A_PIN) return view;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_dir = 0; m_dat = 0; m_pul = 0; m_rdata = 0; m_rcnt = 0;
      m_sync = '{8'h00, 8'h00};
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      m_rdata = rd ? m_read(addr) : 8'h00;
      if (hstby || mrst || sstby) m_sync = '{8'h00, 8'h00};
      else begin void'(m_sync.pop_front()); m_sync.push_back(pin_in); end
      if (hstby) begin
        m_dir = 0; m_dat = 0; m_pul = 0;
      end else if (wr) begin
        if (addr == A_DIR) m_dir = wdata;
        if (addr == A_DAT) m_dat = wdata;
        if (addr == A_PUL) m_pul = wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Every-cycle comparison, 1 ns after the falling edge.
  always begin
    @(negedge clk);
    #1;
    chk("R4 R5 pin_oe",  pin_oe,  bus_mode(mode) ? {8{xbus_oe}} : m_dir);
    chk("R4 R5 pin_out", pin_out, bus_mode(mode) ? xbus_do : m_dat);
    chk("R10 pin_pu",    pin_pu,  bus_mode(mode) ? 8'h00 : (~m_dir & m_pul));
    chk("R11 rdata",     rdata,   m_rdata);
    chk("R9 xbus_di",    xbus_di, m_sync[0]);
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; #1; v = rdata;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    por_n = 0; hstby = 0; mrst = 0; sstby = 0; wr = 0; rd = 0;
    mode = 3'd7; addr = 0; wdata = 0; pin_in = 0; xbus_oe = 0; xbus_do = 0;
    idle(5);
    por_n = 1;
    idle(4); #1;
    chk("R1 oe", pin_oe, 8'h00); chk("R1 out", pin_out, 8'h00); chk("R1 pu", pin_pu, 8'h00);
    rd_reg(A_DAT, v); chk("R1 dat", v, 8'h00);

    wr_reg(A_DIR, 8'hF0); wr_reg(A_DAT, 8'hA5); wr_reg(A_PUL, 8'h0F);
    #1;
    chk("R4 oe", pin_oe, 8'hF0); chk("R4 out", pin_out, 8'hA5); chk("R10 pu", pin_pu, 8'h0F);
    rd_reg(A_DAT, v); chk("R7 dat", v, 8'hA5);
    rd_reg(A_PUL, v); chk("R7 pul", v, 8'h0F);
    rd_reg(A_DIR, v); chk("R6 dir", v, 8'h00);
    rd_reg(16'hFEBD, v); chk("R11 unmapped", v, 8'h00);

    @(negedge clk); pin_in = 8'h3C;
    @(negedge clk); #1; chk("R9 one edge", xbus_di, 8'h00);
    @(negedge clk); #1; chk("R9 two edges", xbus_di, 8'h3C);
    rd_reg(A_PIN, v); chk("R8 pin view", v, 8'hAC);
    wr_reg(A_PIN, 8'h55);
    rd_reg(A_DAT, v); chk("R8 write ignored dat", v, 8'hA5);
    rd_reg(A_PIN, v); chk("R8 write ignored pin", v, 8'hAC);

    @(negedge clk); mode = 3'd5; xbus_oe = 1; xbus_do = 8'h99; #1;
    chk("R5 oe", pin_oe, 8'hFF); chk("R5 out", pin_out, 8'h99); chk("R10 bus pu", pin_pu, 8'h00);
    rd_reg(A_PIN, v); chk("R8 bus view", v, 8'h3C);
    wr_reg(A_DIR, 8'h0F); #1; chk("R5 dir ignored", pin_oe, 8'hFF);
    @(negedge clk); mode = 3'd4; xbus_oe = 0; #1; chk("R5 mode4 oe", pin_oe, 8'h00);
    @(negedge clk); mode = 3'd6; xbus_oe = 1; #1; chk("R5 mode6 oe", pin_oe, 8'hFF);
    @(negedge clk); mode = 3'd7; #1; chk("R4 dir stored", pin_oe, 8'h0F);

    @(negedge clk); mrst = 1;
    @(negedge clk); mrst = 0; #1;
    chk("R3 sync clr", xbus_di, 8'h00); chk("R3 oe kept", pin_oe, 8'h0F); chk("R3 out kept", pin_out, 8'hA5);
    @(negedge clk); sstby = 1; idle(3); sstby = 0;
    rd_reg(A_PUL, v); chk("R3 pul kept", v, 8'h0F);

    @(negedge clk); hstby = 1; addr = A_DIR; wdata = 8'hFF; wr = 1;
    @(negedge clk); hstby = 0; wr = 0; #1;
    chk("R2 oe", pin_oe, 8'h00); chk("R2 out", pin_out, 8'h00); chk("R2 pu", pin_pu, 8'h00);
    rd_reg(A_DAT, v); chk("R2 dat", v, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      case ($urandom_range(0, 4))
        0: addr = A_DIR; 1: addr = A_DAT; 2: addr = A_PIN; 3: addr = A_PUL;
        default: addr = 16'($urandom);
      endcase
      wdata = 8'($urandom); pin_in = 8'($urandom); xbus_do = 8'($urandom);
      xbus_oe = 1'($urandom); wr = ($urandom_range(0, 2) == 0); rd = ($urandom_range(0, 1) == 0);
      mode = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(4, 6)) : 3'd7;
      mrst = ($urandom_range(0, 40) == 0); sstby = ($urandom_range(0, 40) == 0);
      hstby = ($urandom_range(0, 80) == 0);
    end
    @(negedge clk); wr = 0; rd = 0; mrst = 0; sstby = 0; hstby = 0; mode = 3'd7;
    wr_reg(A_DIR, 8'h81); wr_reg(A_DAT, 8'hFF);
    #1; por_n = 0; #0.5;
    chk("R1 async oe", pin_oe, 8'h00); chk("R1 async out", pin_out, 8'h00);
    idle(3); por_n = 1; idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule